// File: doc/BRIEF.md
# Sliding-Window Correlation Lock Detector

This block watches two signed sample streams, for example a driving state variable and the state of a follower that is meant to track it. It decides whether the pair is currently synchronized. It keeps five running sums over the most recent WIN accepted pairs: ΣA, ΣB, ΣA², ΣB² and ΣA·B. A circular delay store lets the oldest pair be subtracted when a new one enters. From those sums it forms the centered cross term and the two centered energies.

The block compares the implied Pearson coefficient against two programmable fractions. The comparison squares both sides and cross-multiplies, so the design needs neither a divider nor a square root, and it never produces the coefficient itself. A lock fraction is typically set near four fifths of the expected synchronized level, and an unlock fraction near one fifth of it. The raw centered cross term is exported as well, so its sign and its size stay visible.

Top module: `corr_lock_top`

## Requirements
- R1: A synchronous active-high reset clears `locked` and `unlocked` to 0 and `cov` to 0, and empties the window.
- R2: A pair is taken only on a rising clock edge where `smp_vld` is 1. While `smp_vld` is 0, the values on `smp_a` and `smp_b` have no effect, and `cov` and the flags hold their values.
- R3: Until WIN pairs have been accepted since reset, `locked` and `unlocked` both stay 0 and `cov` stays 0.
- R4: Once the window is full, `cov` equals WIN·ΣAB − ΣA·ΣB, taken over the newest WIN accepted pairs, as a signed two's-complement value. The oldest pair leaves the sums as each new one arrives.
- R5: When the window is full, `locked` is 1 exactly when all of the following hold: varA = WIN·ΣA² − (ΣA)² is nonzero, varB is nonzero, `cov` ≥ 0, and cov²·2^32 ≥ L²·varA·varB. Here L is `lock_thr`, read as an unsigned Q0.16 fraction L/65536.
- R6: When the window is full, `unlocked` is 1 exactly when at least one of these holds: a variance is zero, `cov` < 0, or cov²·2^32 < U²·varA·varB. Here U is `unlock_thr` in the same Q0.16 format.
- R7: Results that include a pair accepted at clock edge k appear on the outputs after edge k+2. A threshold value present before edge j governs the flags from edge j onward.
- R8: A window in which either stream is constant reports `locked` = 0 and `unlocked` = 1, whatever the thresholds are.
- R9: While `lock_thr` ≥ `unlock_thr`, `locked` and `unlocked` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Qualifies the sample pair on this edge |
| smp_a | input | DATA_W (12) | Signed sample of the first stream |
| smp_b | input | DATA_W (12) | Signed sample of the second stream |
| lock_thr | input | THR_W (16) | Lock fraction, unsigned Q0.16 |
| unlock_thr | input | THR_W (16) | Unlock fraction, unsigned Q0.16 |
| locked | output | 1 | Correlation at or above the lock fraction |
| unlocked | output | 1 | Correlation below the unlock fraction |
| cov | output | 2·DATA_W+2·⌈log2(WIN+1)⌉+2 (46) | Signed centered cross term |

## Verification
A pair accepted at edge k updates the running sums at k and the centered terms at k+1. It reaches `cov` and both flags at k+2. A threshold change needs only the next edge. The latency test samples the outputs halfway between edges after k, k+1 and k+2. It expects the old values twice and the new values on the third sample. Every other comparison lets three idle cycles pass first, so the whole pipeline has settled before the bench compares the outputs with its own sums over the stored history. The threshold test drives the new fraction on a falling edge and reads the flags one rising edge later.

// File: rtl/corr_lock_pkg.sv
package corr_lock_pkg;

    localparam int DEF_DATA_W = 12;
    localparam int DEF_WIN    = 1000;
    localparam int DEF_THR_W  = 16;

    // window occupancy
    typedef enum logic {
        WIN_FILLING = 1'b0,
        WIN_RUNNING = 1'b1
    } win_state_e;

    // second-order sum slots
    typedef enum logic [1:0] {
        TERM_AB = 2'd0,
        TERM_AA = 2'd1,
        TERM_BB = 2'd2
    } term_e;

    localparam int NUM_TERMS = 3;

    function automatic int cnt_bits(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/corr_win_buf.sv
module corr_win_buf
    import corr_lock_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int DEPTH  = DEF_WIN
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic signed [DATA_W-1:0] in_a,
    input  logic signed [DATA_W-1:0] in_b,
    output logic signed [DATA_W-1:0] old_a,
    output logic signed [DATA_W-1:0] old_b,
    output logic                     full
);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int WORD_W = 2 * DATA_W;

    logic [WORD_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [WORD_W-1:0] rd_word;
    win_state_e        state;
    logic              at_end;

    // the slot about to be overwritten holds the oldest pair
    assign rd_word = store[wr_ptr];
    assign old_a   = $signed(rd_word[WORD_W-1 -: DATA_W]);
    assign old_b   = $signed(rd_word[DATA_W-1:0]);
    assign at_end  = (wr_ptr == PTR_W'(DEPTH - 1));
    assign full    = (state == WIN_RUNNING);

    always_ff @(posedge clk) begin
        if (push && !rst) begin
            store[wr_ptr] <= {in_a, in_b};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            state  <= WIN_FILLING;
        end else if (push) begin
            wr_ptr <= at_end ? '0 : wr_ptr + 1'b1;
            if (at_end) begin
                state <= WIN_RUNNING;
            end
        end
    end

endmodule

// File: rtl/corr_run_sums.sv
module corr_run_sums
    import corr_lock_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int CNT_W  = cnt_bits(DEF_WIN),
    parameter int SUM_W  = DATA_W + CNT_W,
    parameter int SQ_W   = 2 * DATA_W + CNT_W + 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               push,
    input  logic                               full,
    input  logic signed [DATA_W-1:0]           in_a,
    input  logic signed [DATA_W-1:0]           in_b,
    input  logic signed [DATA_W-1:0]           old_a,
    input  logic signed [DATA_W-1:0]           old_b,
    output logic signed [SUM_W-1:0]            sum_a,
    output logic signed [SUM_W-1:0]            sum_b,
    output logic [NUM_TERMS-1:0][SQ_W-1:0]     sq
);
    localparam int PR_W = 2 * DATA_W + 1;

    logic signed [SUM_W-1:0] ext_na, ext_nb, ext_oa, ext_ob;

    assign ext_na = {{CNT_W{in_a[DATA_W-1]}}, in_a};
    assign ext_nb = {{CNT_W{in_b[DATA_W-1]}}, in_b};
    assign ext_oa = full ? {{CNT_W{old_a[DATA_W-1]}}, old_a} : '0;
    assign ext_ob = full ? {{CNT_W{old_b[DATA_W-1]}}, old_b} : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_a <= '0;
            sum_b <= '0;
        end else if (push) begin
            sum_a <= sum_a + ext_na - ext_oa;
            sum_b <= sum_b + ext_nb - ext_ob;
        end
    end

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        logic signed [DATA_W-1:0] xn, yn, xo, yo;
        logic signed [PR_W-1:0]   xne, yne, xoe, yoe;
        logic signed [PR_W-1:0]   p_new, p_old;
        logic signed [SQ_W-1:0]   add_v, sub_v;

        if (t == int'(TERM_AB)) begin : g_ab
            assign xn = in_a;  assign yn = in_b;
            assign xo = old_a; assign yo = old_b;
        end else if (t == int'(TERM_AA)) begin : g_aa
            assign xn = in_a;  assign yn = in_a;
            assign xo = old_a; assign yo = old_a;
        end else begin : g_bb
            assign xn = in_b;  assign yn = in_b;
            assign xo = old_b; assign yo = old_b;
        end

        assign xne   = {{(DATA_W+1){xn[DATA_W-1]}}, xn};
        assign yne   = {{(DATA_W+1){yn[DATA_W-1]}}, yn};
        assign xoe   = {{(DATA_W+1){xo[DATA_W-1]}}, xo};
        assign yoe   = {{(DATA_W+1){yo[DATA_W-1]}}, yo};
        assign p_new = xne * yne;
        assign p_old = full ? xoe * yoe : '0;
        assign add_v = {{(SQ_W-PR_W){p_new[PR_W-1]}}, p_new};
        assign sub_v = {{(SQ_W-PR_W){p_old[PR_W-1]}}, p_old};

        always_ff @(posedge clk) begin
            if (rst) begin
                sq[t] <= '0;
            end else if (push) begin
                sq[t] <= $signed(sq[t]) + add_v - sub_v;
            end
        end
    end

endmodule

// File: rtl/corr_center.sv
module corr_center
    import corr_lock_pkg::*;
#(
    parameter int WIN   = DEF_WIN,
    parameter int SUM_W = DEF_DATA_W + cnt_bits(DEF_WIN),
    parameter int SQ_W  = 2 * DEF_DATA_W + cnt_bits(DEF_WIN) + 1,
    parameter int C_W   = 2 * SUM_W + 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             win_full,
    input  logic signed [SUM_W-1:0]          sum_a,
    input  logic signed [SUM_W-1:0]          sum_b,
    input  logic [NUM_TERMS-1:0][SQ_W-1:0]   sq,
    output logic [NUM_TERMS-1:0][C_W-1:0]    cen,
    output logic                             cen_vld
);
    localparam logic signed [C_W-1:0] N_C = C_W'(WIN);

    logic signed [C_W-1:0] ea, eb;

    assign ea = {{(C_W-SUM_W){sum_a[SUM_W-1]}}, sum_a};
    assign eb = {{(C_W-SUM_W){sum_b[SUM_W-1]}}, sum_b};

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_cen
        logic signed [C_W-1:0] sx, sy, sqe, n_sq, s_pr;

        if (t == int'(TERM_AB)) begin : g_ab
            assign sx = ea; assign sy = eb;
        end else if (t == int'(TERM_AA)) begin : g_aa
            assign sx = ea; assign sy = ea;
        end else begin : g_bb
            assign sx = eb; assign sy = eb;
        end

        assign sqe  = {{(C_W-SQ_W){sq[t][SQ_W-1]}}, sq[t]};
        assign n_sq = N_C * sqe;
        assign s_pr = sx * sy;

        always_ff @(posedge clk) begin
            if (rst || !win_full) begin
                cen[t] <= '0;
            end else begin
                cen[t] <= n_sq - s_pr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cen_vld <= 1'b0;
        end else begin
            cen_vld <= win_full;
        end
    end

endmodule

// File: rtl/corr_thr_cmp.sv
module corr_thr_cmp
    import corr_lock_pkg::*;
#(
    parameter int C_W   = 2 * (DEF_DATA_W + cnt_bits(DEF_WIN)) + 2,
    parameter int THR_W = DEF_THR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cen_vld,
    input  logic signed [C_W-1:0]   cov_in,
    input  logic [C_W-1:0]          var_a,
    input  logic [C_W-1:0]          var_b,
    input  logic [THR_W-1:0]        lock_thr,
    input  logic [THR_W-1:0]        unlock_thr,
    output logic                    locked,
    output logic                    unlocked,
    output logic signed [C_W-1:0]   cov_out
);
    localparam int P_W = 2 * C_W + 2 * THR_W;

    logic [P_W-1:0] cov_u, va_u, vb_u, lhs, var_prod;
    logic [1:0][THR_W-1:0] thr;
    logic [1:0] meets;
    logic nondeg, cov_neg;

    assign cov_u    = {{(P_W-C_W){1'b0}}, cov_in};
    assign va_u     = {{(P_W-C_W){1'b0}}, var_a};
    assign vb_u     = {{(P_W-C_W){1'b0}}, var_b};
    assign lhs      = (cov_u * cov_u) << (2 * THR_W);
    assign var_prod = va_u * vb_u;
    assign nondeg   = (var_a != '0) && (var_b != '0);
    assign cov_neg  = cov_in[C_W-1];
    assign thr[0]   = lock_thr;
    assign thr[1]   = unlock_thr;

    // squared form of coefficient >= fraction, one per threshold
    for (genvar i = 0; i < 2; i++) begin : g_cmp
        logic [P_W-1:0] t_u, rhs;
        assign t_u      = {{(P_W-THR_W){1'b0}}, thr[i]};
        assign rhs      = (t_u * t_u) * var_prod;
        assign meets[i] = nondeg && !cov_neg && (lhs >= rhs);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked   <= 1'b0;
            unlocked <= 1'b0;
            cov_out  <= '0;
        end else begin
            locked   <= cen_vld && meets[0];
            unlocked <= cen_vld && !meets[1];
            cov_out  <= cov_in;
        end
    end

endmodule

// File: rtl/corr_lock_top.sv
module corr_lock_top
    import corr_lock_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int WIN    = DEF_WIN,
    parameter int THR_W  = DEF_THR_W
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        smp_vld,
    input  logic signed [DATA_W-1:0]                    smp_a,
    input  logic signed [DATA_W-1:0]                    smp_b,
    input  logic [THR_W-1:0]                            lock_thr,
    input  logic [THR_W-1:0]                            unlock_thr,
    output logic                                        locked,
    output logic                                        unlocked,
    output logic signed [2*DATA_W+2*$clog2(WIN+1)+1:0]  cov
);
    localparam int CNT_W = cnt_bits(WIN);
    localparam int SUM_W = DATA_W + CNT_W;
    localparam int SQ_W  = 2 * DATA_W + CNT_W + 1;
    localparam int C_W   = 2 * SUM_W + 2;

    logic signed [DATA_W-1:0]          old_a, old_b;
    logic                              win_full;
    logic signed [SUM_W-1:0]           sum_a, sum_b;
    logic [NUM_TERMS-1:0][SQ_W-1:0]    sq;
    logic [NUM_TERMS-1:0][C_W-1:0]     cen;
    logic                              cen_vld;

    corr_win_buf #(
        .DATA_W (DATA_W),
        .DEPTH  (WIN)
    ) u_buf (
        .clk   (clk),
        .rst   (rst),
        .push  (smp_vld),
        .in_a  (smp_a),
        .in_b  (smp_b),
        .old_a (old_a),
        .old_b (old_b),
        .full  (win_full)
    );

    corr_run_sums #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .SUM_W  (SUM_W),
        .SQ_W   (SQ_W)
    ) u_sums (
        .clk   (clk),
        .rst   (rst),
        .push  (smp_vld),
        .full  (win_full),
        .in_a  (smp_a),
        .in_b  (smp_b),
        .old_a (old_a),
        .old_b (old_b),
        .sum_a (sum_a),
        .sum_b (sum_b),
        .sq    (sq)
    );

    // window is complete once the sums hold WIN pairs
    corr_center #(
        .WIN   (WIN),
        .SUM_W (SUM_W),
        .SQ_W  (SQ_W),
        .C_W   (C_W)
    ) u_center (
        .clk      (clk),
        .rst      (rst),
        .win_full (win_full),
        .sum_a    (sum_a),
        .sum_b    (sum_b),
        .sq       (sq),
        .cen      (cen),
        .cen_vld  (cen_vld)
    );

    corr_thr_cmp #(
        .C_W   (C_W),
        .THR_W (THR_W)
    ) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .cen_vld    (cen_vld),
        .cov_in     ($signed(cen[TERM_AB])),
        .var_a      (cen[TERM_AA]),
        .var_b      (cen[TERM_BB]),
        .lock_thr   (lock_thr),
        .unlock_thr (unlock_thr),
        .locked     (locked),
        .unlocked   (unlocked),
        .cov_out    (cov)
    );

endmodule

// File: rtl/corr_lock_chk.sv
module corr_lock_chk
    import corr_lock_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int WIN    = DEF_WIN,
    parameter int THR_W  = DEF_THR_W
) (
    input logic                                        clk,
    input logic                                        rst,
    input logic                                        smp_vld,
    input logic [THR_W-1:0]                            lock_thr,
    input logic [THR_W-1:0]                            unlock_thr,
    input logic                                        locked,
    input logic                                        unlocked,
    input logic signed [2*DATA_W+2*$clog2(WIN+1)+1:0]  cov
);
    localparam int CNT_W = cnt_bits(WIN);

    logic [CNT_W-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (smp_vld && (seen != CNT_W'(WIN))) begin
            seen <= seen + 1'b1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!locked && !unlocked && cov == '0)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(smp_vld, 3) && !$past(rst)) |-> $stable(cov)); // R2

    AST_FILL_GATES: assert property (@(posedge clk) disable iff (rst)
        (seen != CNT_W'(WIN)) |-> (!locked && !unlocked && cov == '0)); // R3

    AST_NEG_NOT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (cov < 0) |-> !locked); // R5

    AST_NEG_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        (cov < 0) |-> unlocked); // R6

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        ($stable(lock_thr) && $stable(unlock_thr) && lock_thr >= unlock_thr)
        |-> !(locked && unlocked)); // R9

endmodule

bind corr_lock_top corr_lock_chk #(
    .DATA_W (DATA_W),
    .WIN    (WIN),
    .THR_W  (THR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_vld    (smp_vld),
    .lock_thr   (lock_thr),
    .unlock_thr (unlock_thr),
    .locked     (locked),
    .unlocked   (unlocked),
    .cov        (cov)
);

// File: tb/corr_lock_top_tb.sv
module corr_lock_top_tb;
    localparam int DW  = 12;
    localparam int WIN = 1000;
    localparam int TW  = 16;
    localparam int C_W = 2 * DW + 2 * $clog2(WIN + 1) + 2;

    localparam int P_SAME = 0, P_NEG = 1, P_INDEP = 2, P_NOISY = 3, P_CONST = 4;

    // {pattern[36:34], lock_thr[33:18], unlock_thr[17:2], exp_locked, exp_unlocked}
    localparam logic [36:0] VEC [7] = '{
        {3'd0, 16'hCCCD, 16'h3333, 1'b1, 1'b0},
        {3'd1, 16'hCCCD, 16'h3333, 1'b0, 1'b1},
        {3'd2, 16'hCCCD, 16'h3333, 1'b0, 1'b1},
        {3'd3, 16'hCCCD, 16'h3333, 1'b0, 1'b0},
        {3'd3, 16'h999A, 16'h3333, 1'b1, 1'b0},
        {3'd4, 16'hCCCD, 16'h3333, 1'b0, 1'b1},
        {3'd0, 16'hFFFF, 16'h3333, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst;
    logic smp_vld;
    logic signed [DW-1:0] smp_a, smp_b;
    logic [TW-1:0] lock_thr, unlock_thr;
    logic locked, unlocked;
    logic signed [C_W-1:0] cov;

    int checks = 0;
    int errors = 0;
    int ha [WIN];
    int hb [WIN];
    int hpos = 0;
    int hcount = 0;
    logic [31:0] r1 = 32'h1234_5678;
    logic [31:0] r2 = 32'h9E37_79B9;

    always #10 clk = ~clk;

    corr_lock_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .smp_vld    (smp_vld),
        .smp_a      (smp_a),
        .smp_b      (smp_b),
        .lock_thr   (lock_thr),
        .unlock_thr (unlock_thr),
        .locked     (locked),
        .unlocked   (unlocked),
        .cov        (cov)
    );

    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] v = s;
        v = v ^ (v << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    task automatic chk(input string tag, input logic signed [127:0] act,
                       input logic signed [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input int a, input int b);
        smp_vld = 1'b1;
        smp_a   = DW'(a);
        smp_b   = DW'(b);
        @(negedge clk);
        ha[hpos] = a;
        hb[hpos] = b;
        hpos     = (hpos + 1) % WIN;
        hcount++;
    endtask

    task automatic idle(input int n);
        smp_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic gen(input int pat, output int a, output int b);
        int n;
        r1 = xs(r1);
        r2 = xs(r2);
        a = int'(r1[10:0]) - 1024;
        n = int'(r2[10:0]) - 1024;
        case (pat)
            P_SAME:  b = a;
            P_NEG:   b = -a;
            P_INDEP: b = n;
            P_NOISY: b = a + n;
            default: b = 500;
        endcase
    endtask

    task automatic feed(input int pat, input int count);
        int a, b;
        for (int i = 0; i < count; i++) begin
            gen(pat, a, b);
            push(a, b);
        end
    endtask

    task automatic model(output logic signed [127:0] c, output logic signed [127:0] va,
                         output logic signed [127:0] vb);
        longint sa = 0, sb = 0, saa = 0, sbb = 0, sab = 0;
        logic signed [127:0] n = 128'(WIN);
        if (hcount < WIN) begin
            c = 0; va = 0; vb = 0;
        end else begin
            for (int i = 0; i < WIN; i++) begin
                sa  += longint'(ha[i]);
                sb  += longint'(hb[i]);
                saa += longint'(ha[i]) * longint'(ha[i]);
                sbb += longint'(hb[i]) * longint'(hb[i]);
                sab += longint'(ha[i]) * longint'(hb[i]);
            end
            c  = n * 128'(sab) - 128'(sa) * 128'(sb);
            va = n * 128'(saa) - 128'(sa) * 128'(sa);
            vb = n * 128'(sbb) - 128'(sb) * 128'(sb);
        end
    endtask

    function automatic bit meets(input logic signed [127:0] c, input logic signed [127:0] va,
                                 input logic signed [127:0] vb, input logic [15:0] thr);
        logic signed [127:0] t = {112'd0, thr};
        if (va == 0 || vb == 0 || c < 0) return 1'b0;
        return ((c * c) <<< 32) >= (t * t * va * vb);
    endfunction

    // compare all outputs against the bench's own window sums
    task automatic check_model(input string tag);
        logic signed [127:0] c, va, vb;
        bit full, el, eu;
        model(c, va, vb);
        full = (hcount >= WIN);
        el = full && meets(c, va, vb, lock_thr);
        eu = full && !meets(c, va, vb, unlock_thr);
        chk({tag, " R4 cov"}, 128'(cov), c);
        chk({tag, " R5 locked"}, {127'd0, locked}, {127'd0, el});
        chk({tag, " R6 unlocked"}, {127'd0, unlocked}, {127'd0, eu});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R7: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic signed [127:0] held;
        logic [36:0] v;
        rst        = 1'b1;
        smp_vld    = 1'b0;
        smp_a      = '0;
        smp_b      = '0;
        lock_thr   = 16'hCCCD;
        unlock_thr = 16'h3333;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: outputs after reset
        chk("R1 locked", {127'd0, locked}, 0);
        chk("R1 unlocked", {127'd0, unlocked}, 0);
        chk("R1 cov", 128'(cov), 0);

        // R3: one pair short of a full window
        feed(P_SAME, WIN - 1);
        idle(3);
        chk("R3 locked before fill", {127'd0, locked}, 0);
        chk("R3 unlocked before fill", {127'd0, unlocked}, 0);
        chk("R3 cov before fill", 128'(cov), 0);

        // R7: last pair accepted at edge k, outputs due after k+2
        feed(P_SAME, 1);
        chk("R7 locked after k", {127'd0, locked}, 0);
        idle(1);
        chk("R7 locked after k+1", {127'd0, locked}, 0);
        idle(1);
        chk("R7 locked after k+2", {127'd0, locked}, 1);
        check_model("R7 first window");

        // R2: input values without smp_vld are ignored
        held = 128'(cov);
        for (int i = 0; i < 10; i++) begin
            smp_a = DW'(-2048 + 397 * i);
            smp_b = DW'(2047 - 211 * i);
            @(negedge clk);
        end
        idle(3);
        chk("R2 cov held", 128'(cov), held);
        chk("R2 locked held", {127'd0, locked}, 1);

        // table of windows: pattern, thresholds, expected flags
        for (int e = 0; e < 7; e++) begin
            v = VEC[e];
            lock_thr   = v[33:18];
            unlock_thr = v[17:2];
            feed(int'(v[36:34]), WIN);
            idle(3);
            check_model("table");
            chk((v[36:34] == 3'd4) ? "R8 locked constant" : "R5 locked table",
                {127'd0, locked}, {127'd0, v[1]});
            chk((v[36:34] == 3'd4) ? "R8 unlocked constant" : "R6 unlocked table",
                {127'd0, unlocked}, {127'd0, v[0]});
            chk("R9 exclusive", {127'd0, locked && unlocked}, 0);
        end

        // R7: threshold change takes effect on the next edge
        lock_thr = 16'hCCCD;
        feed(P_NOISY, WIN);
        idle(3);
        chk("R7 noisy not locked", {127'd0, locked}, 0);
        lock_thr = 16'h999A;
        @(negedge clk);
        chk("R7 locked one edge after threshold", {127'd0, locked}, 1);
        lock_thr = 16'hCCCD;
        @(negedge clk);
        chk("R7 released one edge after threshold", {127'd0, locked}, 0);

        // R4: sliding window mixing two patterns
        feed(P_SAME, WIN);
        feed(P_NEG, 300);
        idle(3);
        check_model("R4 mixed window");
        feed(P_NEG, 450);
        idle(3);
        check_model("R4 mostly opposite");

        // R1: reset in the middle of a run, then R3 on a partial window
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        hcount = 0;
        hpos = 0;
        @(negedge clk);
        chk("R1 cov after mid reset", 128'(cov), 0);
        chk("R1 unlocked after mid reset", {127'd0, unlocked}, 0);
        feed(P_NEG, 5);
        idle(3);
        chk("R3 unlocked partial after reset", {127'd0, unlocked}, 0);
        chk("R3 cov partial after reset", 128'(cov), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule